// File: doc/BRIEF.md
# NAND Flash Command and Address Sequencer

This block runs the bus side of an 8-bit raw NAND flash device for a host. The host gives an operation code, a 29-bit byte address and a one-cycle start pulse. The block then generates the device sequence on the command-latch, address-latch, write-strobe, read-strobe and chip-enable pins and on the 8-bit data bus with its output enable. Bytes read from the device come back on a valid/ready stream. A one-cycle done pulse closes each operation.

The block supports three operations: device reset, identification read and page read. Every bus cycle follows one three-phase timing. The latch signal is set up first, the strobe is then held active, and the latch is held afterwards. Three run-time inputs set the length of each phase.

The device ready/busy line is synchronised and edge-detected into a sticky flag. The sequencer clears this flag when it accepts an operation. It waits for the flag before it reads page data. Software can also clear the flag by writing 1.

An identification read latches the device code as a page-size class. A later page read uses that class to decide how many bytes to stream.

Top module: `nand_seq_top`

## Requirements
- R1: After reset: chip enable, write strobe and read strobe are high; both latch signals are low; the output enable is low; busy, done and rd_valid are low; page_kind is 0; rnb_flag is 0.
- R2: Every bus cycle has three phases. The latch signal (command latch for a command, address latch for an address) is high for cfg_setup cycles before the strobe goes low. The strobe (write strobe for a command or address, read strobe for a data read) is low for cfg_width+1 cycles. The latch stays high for cfg_hold cycles after the strobe rises. The write strobe is never low without one of the latches high.
- R3: A page read sends five address bytes in this order: A7..A0; {0000, A11..A8}; A19..A12; A27..A20; {0000000, A28}.
- R4: A page read (op_code 2) sends command 0x00, the five address bytes and command 0x30. It then waits for rnb_flag and reads bytes. The count is 512 bytes when page_kind is 1 and 2048 bytes otherwise. No read strobe comes before the device ready line has risen.
- R5: A reset (op_code 0) sends the single command 0xFF with no address byte. Done comes only after the device ready line has risen.
- R6: An identification read (op_code 1) sends command 0x90, then one address byte 0x00, then four read strobes. The four bytes are delivered in device order.
- R7: The second identification byte sets page_kind. 0x76 gives 1 (512-byte pages). 0xF1, 0xD3, 0xDA or 0xDC gives 2 (2048-byte pages). Any other value gives 0.
- R8: Chip enable is low for the whole operation, including during every strobe. It is high in the cycle done is asserted and whenever the block is not busy.
- R9: The output enable is high only during command and address bus cycles. It is never high while the read strobe is low, while waiting for ready, or while idle.
- R10: rnb_flag is set by a rising edge of the ready line after a two-flop synchroniser. It is cleared by rnb_flag_clr and when an operation is accepted. A set in the same cycle wins over a clear.
- R11: A start pulse while busy is ignored. A start with op_code 3 is ignored.
- R12: rd_data holds steady while rd_valid is high and rd_ready is low. No next read strobe starts until the previous byte is taken. Done is a single-cycle pulse that comes only after the last byte is taken.
- R13: The command latch and the address latch are never high together. The write strobe and the read strobe are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | One-cycle request to begin an operation |
| op_code | input | 2 | 0 reset, 1 identification read, 2 page read, 3 none |
| op_addr | input | 29 | Byte address for a page read |
| cfg_setup | input | TW | Latch setup cycles before the strobe |
| cfg_width | input | TW | Strobe active cycles minus one |
| cfg_hold | input | TW | Latch hold cycles after the strobe |
| op_busy | output | 1 | Operation in progress |
| op_done | output | 1 | One-cycle end-of-operation pulse |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Host takes the read byte |
| rd_data | output | 8 | Read byte |
| page_kind | output | 2 | Page class latched by the identification read |
| rnb_flag | output | 1 | Sticky ready-rise flag |
| rnb_flag_clr | input | 1 | Write-1 clear of rnb_flag |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_io_out | output | 8 | Data bus output value |
| nf_io_oe | output | 1 | Data bus output enable |
| nf_io_in | input | 8 | Data bus input value |
| nf_rnb | input | 1 | Device ready (high) / busy (low) |

## Verification
The assertions check the pin rules on every cycle:
- the two latches are exclusive, and so are the two strobes;
- the write strobe never appears without a latch;
- chip enable is low during every strobe and high when idle;
- the bus is not driven while the read strobe is low or while idle;
- done is a single cycle and comes only after the stream is drained;
- read data stays stable under back-pressure.

The exact phase lengths, the order and values of command and address bytes, the gating of reads by the ready rise, the page-class decode, the byte count per page class and the disregard of starts while busy all need a device model and stored history. Only the directed scenarios can show those.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam int ADDR_BITS = 29;

  typedef enum logic [1:0] {
    OPC_RESET  = 2'd0,
    OPC_READID = 2'd1,
    OPC_PAGE   = 2'd2,
    OPC_NONE   = 2'd3
  } host_op_e;

  typedef enum logic [1:0] {
    BUS_CMD  = 2'd0,
    BUS_ADDR = 2'd1,
    BUS_READ = 2'd2
  } bus_kind_e;

  typedef enum logic [1:0] {
    PG_UNKNOWN = 2'd0,
    PG_SMALL   = 2'd1,
    PG_LARGE   = 2'd2
  } page_kind_e;

  localparam logic [7:0] CMD_DEV_RESET = 8'hFF;
  localparam logic [7:0] CMD_PAGE_OPEN = 8'h00;
  localparam logic [7:0] CMD_PAGE_GO   = 8'h30;
  localparam logic [7:0] CMD_IDENT     = 8'h90;

endpackage

// File: rtl/nand_rnb_edge.sv
module nand_rnb_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic rnb,
  input  logic clr_sw,
  input  logic clr_seq,
  output logic flag
);
  logic [2:0] sync_q, sync_d;
  logic       flag_q, flag_d;
  logic       rise;

  always_comb begin
    sync_d = {sync_q[1:0], rnb};
    rise   = sync_q[1] & ~sync_q[2];
    flag_d = flag_q;
    if (clr_sw || clr_seq) flag_d = 1'b0;
    if (rise)              flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 3'b111;
      flag_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/nand_bus_timer.sv
module nand_bus_timer
  import nand_seq_pkg::*;
#(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  bus_kind_e     go_kind,
  input  logic [7:0]    go_byte,
  input  logic [TW-1:0] t_setup,
  input  logic [TW-1:0] t_width,
  input  logic [TW-1:0] t_hold,
  output logic          idle,
  output logic          cyc_done,
  output logic          cap,
  output logic          cle,
  output logic          ale,
  output logic          we_n,
  output logic          re_n,
  output logic [7:0]    io_out,
  output logic          io_oe
);
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACT, PH_HOLD} phase_e;

  phase_e        ph_q, ph_d;
  logic [TW-1:0] cnt_q, cnt_d;
  bus_kind_e     kind_q, kind_d;
  logic [7:0]    byte_q, byte_d;
  logic          cle_q, ale_q, we_n_q, re_n_q, oe_q;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    kind_d = kind_q;
    byte_d = byte_q;
    unique case (ph_q)
      PH_IDLE: if (go) begin
        kind_d = go_kind;
        byte_d = go_byte;
        if (t_setup != '0) begin
          ph_d  = PH_SETUP;
          cnt_d = t_setup - 1'b1;
        end else begin
          ph_d  = PH_ACT;
          cnt_d = t_width;
        end
      end
      PH_SETUP: if (cnt_q == '0) begin
        ph_d  = PH_ACT;
        cnt_d = t_width;
      end else cnt_d = cnt_q - 1'b1;
      PH_ACT: if (cnt_q == '0) begin
        if (t_hold != '0) begin
          ph_d  = PH_HOLD;
          cnt_d = t_hold - 1'b1;
        end else ph_d = PH_IDLE;
      end else cnt_d = cnt_q - 1'b1;
      PH_HOLD: if (cnt_q == '0) ph_d = PH_IDLE;
               else cnt_d = cnt_q - 1'b1;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      kind_q <= BUS_CMD;
      byte_q <= '0;
      cle_q  <= 1'b0;
      ale_q  <= 1'b0;
      we_n_q <= 1'b1;
      re_n_q <= 1'b1;
      oe_q   <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      kind_q <= kind_d;
      byte_q <= byte_d;
      cle_q  <= (ph_d != PH_IDLE) && (kind_d == BUS_CMD);
      ale_q  <= (ph_d != PH_IDLE) && (kind_d == BUS_ADDR);
      we_n_q <= !((ph_d == PH_ACT) && (kind_d != BUS_READ));
      re_n_q <= !((ph_d == PH_ACT) && (kind_d == BUS_READ));
      oe_q   <= (ph_d != PH_IDLE) && (kind_d != BUS_READ);
    end
  end

  assign idle     = (ph_q == PH_IDLE);
  assign cyc_done = ((ph_q == PH_ACT) && (cnt_q == '0) && (t_hold == '0)) ||
                    ((ph_q == PH_HOLD) && (cnt_q == '0));
  assign cap      = (ph_q == PH_ACT) && (cnt_q == '0) && (kind_q == BUS_READ);
  assign cle      = cle_q;
  assign ale      = ale_q;
  assign we_n     = we_n_q;
  assign re_n     = re_n_q;
  assign io_out   = byte_q;
  assign io_oe    = oe_q;
endmodule

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
#(
  parameter int SMALL_BYTES = 512,
  parameter int LARGE_BYTES = 2048
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  host_op_e             op,
  input  logic [ADDR_BITS-1:0] addr,
  output logic                 busy,
  output logic                 done,
  output logic                 rd_valid,
  input  logic                 rd_ready,
  output logic [7:0]           rd_data,
  output page_kind_e           page_kind,
  output logic                 ce_n,
  output logic                 go,
  output bus_kind_e            go_kind,
  output logic [7:0]           go_byte,
  input  logic                 tmr_idle,
  input  logic                 tmr_done,
  input  logic                 tmr_cap,
  input  logic [7:0]           io_in,
  input  logic                 flag,
  output logic                 seq_clr
);
  localparam int CNT_W = $clog2(LARGE_BYTES + 1);

  typedef enum logic [1:0] {C_IDLE, C_RUN, C_BUS} cstate_e;
  typedef enum logic [2:0] {A_CMD, A_ADDR, A_WAIT, A_READ, A_END} act_e;

  cstate_e              st_q, st_d;
  host_op_e             op_q, op_d;
  logic [ADDR_BITS-1:0] addr_q, addr_d;
  logic [3:0]           step_q, step_d;
  logic [CNT_W-1:0]     rcnt_q, rcnt_d, rd_len;
  logic                 done_q, done_d, ce_q, ce_d, rv_q, rv_d;
  logic [7:0]           rdat_q, rdat_d;
  page_kind_e           pk_q, pk_d;
  act_e                 act;
  logic [7:0]           abyte;

  function automatic page_kind_e classify(input logic [7:0] dev);
    case (dev)
      8'h76:                      return PG_SMALL;
      8'hF1, 8'hD3, 8'hDA, 8'hDC: return PG_LARGE;
      default:                    return PG_UNKNOWN;
    endcase
  endfunction

  // Step program for each operation
  always_comb begin
    act   = A_END;
    abyte = 8'h00;
    rd_len = CNT_W'(4);
    unique case (op_q)
      OPC_RESET: case (step_q)
        4'd0:    begin act = A_CMD; abyte = CMD_DEV_RESET; end
        4'd1:    act = A_WAIT;
        default: act = A_END;
      endcase
      OPC_READID: case (step_q)
        4'd0:    begin act = A_CMD;  abyte = CMD_IDENT; end
        4'd1:    begin act = A_ADDR; abyte = 8'h00; end
        4'd2:    act = A_READ;
        default: act = A_END;
      endcase
      OPC_PAGE: begin
        rd_len = (pk_q == PG_SMALL) ? CNT_W'(SMALL_BYTES) : CNT_W'(LARGE_BYTES);
        case (step_q)
          4'd0:    begin act = A_CMD;  abyte = CMD_PAGE_OPEN; end
          4'd1:    begin act = A_ADDR; abyte = addr_q[7:0]; end
          4'd2:    begin act = A_ADDR; abyte = {4'h0, addr_q[11:8]}; end
          4'd3:    begin act = A_ADDR; abyte = addr_q[19:12]; end
          4'd4:    begin act = A_ADDR; abyte = addr_q[27:20]; end
          4'd5:    begin act = A_ADDR; abyte = {7'h00, addr_q[28]}; end
          4'd6:    begin act = A_CMD;  abyte = CMD_PAGE_GO; end
          4'd7:    act = A_WAIT;
          4'd8:    act = A_READ;
          default: act = A_END;
        endcase
      end
      default: act = A_END;
    endcase
  end

  always_comb begin
    st_d    = st_q;
    op_d    = op_q;
    addr_d  = addr_q;
    step_d  = step_q;
    rcnt_d  = rcnt_q;
    done_d  = 1'b0;
    ce_d    = ce_q;
    rv_d    = rv_q;
    rdat_d  = rdat_q;
    pk_d    = pk_q;
    go      = 1'b0;
    seq_clr = 1'b0;
    if (rv_q && rd_ready) rv_d = 1'b0;
    if (tmr_cap) begin
      rv_d   = 1'b1;
      rdat_d = io_in;
      if (op_q == OPC_READID && rcnt_q == CNT_W'(1)) pk_d = classify(io_in);
    end
    unique case (st_q)
      C_IDLE: if (start && op != OPC_NONE) begin
        op_d    = op;
        addr_d  = addr;
        step_d  = '0;
        rcnt_d  = '0;
        ce_d    = 1'b0;
        seq_clr = 1'b1;
        st_d    = C_RUN;
      end
      C_RUN: case (act)
        A_CMD, A_ADDR: if (tmr_idle) begin
          go   = 1'b1;
          st_d = C_BUS;
        end
        A_WAIT: if (flag) step_d = step_q + 4'd1;
        A_READ: if (tmr_idle && !rv_q) begin
          go   = 1'b1;
          st_d = C_BUS;
        end
        default: if (!rv_q) begin
          done_d = 1'b1;
          ce_d   = 1'b1;
          st_d   = C_IDLE;
        end
      endcase
      C_BUS: if (tmr_done) begin
        st_d = C_RUN;
        if (act == A_READ) begin
          if (rcnt_q == rd_len - 1'b1) begin
            rcnt_d = '0;
            step_d = step_q + 4'd1;
          end else rcnt_d = rcnt_q + 1'b1;
        end else step_d = step_q + 4'd1;
      end
      default: st_d = C_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= C_IDLE;
      op_q   <= OPC_NONE;
      addr_q <= '0;
      step_q <= '0;
      rcnt_q <= '0;
      done_q <= 1'b0;
      ce_q   <= 1'b1;
      rv_q   <= 1'b0;
      rdat_q <= '0;
      pk_q   <= PG_UNKNOWN;
    end else begin
      st_q   <= st_d;
      op_q   <= op_d;
      addr_q <= addr_d;
      step_q <= step_d;
      rcnt_q <= rcnt_d;
      done_q <= done_d;
      ce_q   <= ce_d;
      rv_q   <= rv_d;
      rdat_q <= rdat_d;
      pk_q   <= pk_d;
    end
  end

  assign busy      = (st_q != C_IDLE);
  assign done      = done_q;
  assign rd_valid  = rv_q;
  assign rd_data   = rdat_q;
  assign page_kind = pk_q;
  assign ce_n      = ce_q;
  assign go_byte   = abyte;
  assign go_kind   = (act == A_CMD) ? BUS_CMD : (act == A_ADDR) ? BUS_ADDR : BUS_READ;
endmodule

// File: rtl/nand_seq_top.sv
module nand_seq_top
  import nand_seq_pkg::*;
#(
  parameter int TW          = 4,
  parameter int SMALL_BYTES = 512,
  parameter int LARGE_BYTES = 2048
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_start,
  input  logic [1:0]           op_code,
  input  logic [ADDR_BITS-1:0] op_addr,
  input  logic [TW-1:0]        cfg_setup,
  input  logic [TW-1:0]        cfg_width,
  input  logic [TW-1:0]        cfg_hold,
  output logic                 op_busy,
  output logic                 op_done,
  output logic                 rd_valid,
  input  logic                 rd_ready,
  output logic [7:0]           rd_data,
  output logic [1:0]           page_kind,
  output logic                 rnb_flag,
  input  logic                 rnb_flag_clr,
  output logic                 nf_cle,
  output logic                 nf_ale,
  output logic                 nf_we_n,
  output logic                 nf_re_n,
  output logic                 nf_ce_n,
  output logic [7:0]           nf_io_out,
  output logic                 nf_io_oe,
  input  logic [7:0]           nf_io_in,
  input  logic                 nf_rnb
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  logic       go, tmr_idle, tmr_done, tmr_cap, seq_clr;
  bus_kind_e  go_kind;
  logic [7:0] go_byte;
  page_kind_e pk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  nand_seq_ctrl #(.SMALL_BYTES(SMALL_BYTES), .LARGE_BYTES(LARGE_BYTES)) ctrl_i (
    .clk(clk), .rst_n(rst_core_n), .start(op_start), .op(host_op_e'(op_code)),
    .addr(op_addr), .busy(op_busy), .done(op_done), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .page_kind(pk), .ce_n(nf_ce_n),
    .go(go), .go_kind(go_kind), .go_byte(go_byte), .tmr_idle(tmr_idle),
    .tmr_done(tmr_done), .tmr_cap(tmr_cap), .io_in(nf_io_in),
    .flag(rnb_flag), .seq_clr(seq_clr)
  );

  nand_bus_timer #(.TW(TW)) tmr_i (
    .clk(clk), .rst_n(rst_core_n), .go(go), .go_kind(go_kind), .go_byte(go_byte),
    .t_setup(cfg_setup), .t_width(cfg_width), .t_hold(cfg_hold),
    .idle(tmr_idle), .cyc_done(tmr_done), .cap(tmr_cap),
    .cle(nf_cle), .ale(nf_ale), .we_n(nf_we_n), .re_n(nf_re_n),
    .io_out(nf_io_out), .io_oe(nf_io_oe)
  );

  nand_rnb_edge rnb_i (
    .clk(clk), .rst_n(rst_core_n), .rnb(nf_rnb), .clr_sw(rnb_flag_clr),
    .clr_seq(seq_clr), .flag(rnb_flag)
  );

  assign page_kind = pk;
endmodule

// File: rtl/nand_seq_checker.sv
module nand_seq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       nf_cle,
  input logic       nf_ale,
  input logic       nf_we_n,
  input logic       nf_re_n,
  input logic       nf_ce_n,
  input logic       nf_io_oe,
  input logic       op_busy,
  input logic       op_done,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data
);
  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(nf_cle && nf_ale)); // R13
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!nf_we_n && !nf_re_n)); // R13
  AST_WE_WITH_LATCH: assert property (@(posedge clk) disable iff (!rst_n) !nf_we_n |-> (nf_cle || nf_ale)); // R2
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n) !nf_re_n |-> !nf_io_oe); // R9
  AST_NO_DRIVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !op_busy |-> !nf_io_oe); // R9
  AST_CE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n) (!nf_we_n || !nf_re_n) |-> !nf_ce_n); // R8
  AST_CE_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !op_busy |-> nf_ce_n); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) op_done |=> !op_done); // R12
  AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n) op_done |-> !rd_valid); // R12
  AST_RD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R12
endmodule

bind nand_seq_top nand_seq_checker chk_i (
  .clk(clk), .rst_n(rst_n), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n),
  .nf_re_n(nf_re_n), .nf_ce_n(nf_ce_n), .nf_io_oe(nf_io_oe), .op_busy(op_busy),
  .op_done(op_done), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
);

// File: tb/nand_seq_top_tb_top.sv
`timescale 1ns/1ps
module nand_seq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_start = 1'b0;
  logic [1:0]  op_code = 2'd0;
  logic [28:0] op_addr = '0;
  logic [3:0]  cfg_setup = 4'd0, cfg_width = 4'd6, cfg_hold = 4'd2;
  logic        op_busy, op_done, rd_valid, rd_ready;
  logic [7:0]  rd_data;
  logic [1:0]  page_kind;
  logic        rnb_flag, rnb_flag_clr = 1'b0;
  logic        nf_cle, nf_ale, nf_we_n, nf_re_n, nf_ce_n, nf_io_oe;
  logic [7:0]  nf_io_out, nf_io_in;
  logic        nf_rnb;

  always #5 clk = ~clk;

  nand_seq_top dut_i (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_code(op_code), .op_addr(op_addr),
    .cfg_setup(cfg_setup), .cfg_width(cfg_width), .cfg_hold(cfg_hold),
    .op_busy(op_busy), .op_done(op_done), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .page_kind(page_kind), .rnb_flag(rnb_flag),
    .rnb_flag_clr(rnb_flag_clr), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n),
    .nf_re_n(nf_re_n), .nf_ce_n(nf_ce_n), .nf_io_out(nf_io_out), .nf_io_oe(nf_io_oe),
    .nf_io_in(nf_io_in), .nf_rnb(nf_rnb)
  );

  int nchk = 0, nfail = 0, cyc = 0;
  logic throttle = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;
  assign rd_ready = !throttle || (cyc % 3 == 0);

  // Device model and pin monitor
  logic       rnb_q = 1'b1;
  int         busy_left = 0, ridx = 0, addr_seen = 0;
  logic [7:0] seed = 8'h00;
  logic       id_mode = 1'b0;
  logic [7:0] id_b [4];
  assign nf_rnb   = rnb_q;
  assign nf_io_in = id_mode ? id_b[ridx[1:0]] : (ridx[7:0] ^ seed);

  logic       prev_we = 1'b1, prev_re = 1'b1, prev_strb = 1'b0, seen = 1'b0, lat_cle = 1'b0;
  logic [7:0] lat_b = 8'h00;
  int         pre = 0, low = 0, post = 0, nlog = 0;
  logic [7:0] lg_b [16];
  logic       lg_cmd [16];
  int         lg_pre [16], lg_low [16], lg_post [16];
  int         re_run = 0, re_last = 0, first_re = -1, rise_cyc = -1;
  int         done_cyc = -1, ndone = 0, oe_rd_bad = 0, rcnt = 0;
  logic [7:0] rbuf [2048];

  always @(negedge clk) begin
    logic strb;
    if (busy_left > 0) begin
      busy_left--;
      if (busy_left == 0) begin rnb_q = 1'b1; rise_cyc = cyc; end
    end
    strb = nf_cle | nf_ale;
    if (strb) begin
      if (!nf_we_n) begin low++; seen = 1'b1; lat_b = nf_io_out; lat_cle = nf_cle; end
      else if (seen) post++;
      else pre++;
    end else if (prev_strb) begin
      if (nlog < 16) begin
        lg_b[nlog] = lat_b; lg_cmd[nlog] = lat_cle;
        lg_pre[nlog] = pre; lg_low[nlog] = low; lg_post[nlog] = post;
      end
      nlog++;
      pre = 0; low = 0; post = 0; seen = 1'b0;
    end
    if (!prev_we && nf_we_n) begin
      if (lat_cle) begin
        if (lat_b == 8'hFF || lat_b == 8'h30) begin rnb_q = 1'b0; busy_left = 20; end
        if (lat_b == 8'h90) begin id_mode = 1'b1; ridx = 0; end
        if (lat_b == 8'h00) begin id_mode = 1'b0; ridx = 0; addr_seen = 0; end
      end else begin
        if (addr_seen == 2) seed = lat_b;
        addr_seen++;
      end
    end
    if (!nf_re_n) begin
      re_run++;
      if (nf_io_oe) oe_rd_bad++;
      if (first_re < 0) first_re = cyc;
    end
    if (!prev_re && nf_re_n) begin re_last = re_run; re_run = 0; ridx++; end
    if (rd_valid && rd_ready) begin
      if (rcnt < 2048) rbuf[rcnt] = rd_data;
      rcnt++;
    end
    if (op_done) begin ndone++; done_cyc = cyc; end
    prev_we = nf_we_n; prev_re = nf_re_n; prev_strb = strb;
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  task automatic launch(input logic [1:0] code, input logic [28:0] a);
    nlog = 0; rcnt = 0; ndone = 0; first_re = -1; oe_rd_bad = 0; rise_cyc = -1;
    op_code = code; op_addr = a; op_start = 1'b1;
    tick();
    op_start = 1'b0;
  endtask

  task automatic wait_done();
    while (ndone == 0) tick();
    repeat (3) tick();
  endtask

  task automatic t_reset_state();
    chk(nf_ce_n && nf_we_n && nf_re_n, "R1 strobes idle", {nf_ce_n, nf_we_n, nf_re_n}, 3'b111);
    chk(!nf_cle && !nf_ale && !nf_io_oe, "R1 latches/oe", {nf_cle, nf_ale, nf_io_oe}, 0);
    chk(!op_busy && !op_done && !rd_valid, "R1 host side", {op_busy, op_done, rd_valid}, 0);
    chk(page_kind == 2'd0 && !rnb_flag, "R1 kind/flag", {page_kind, rnb_flag}, 0);
    launch(2'd3, '0);
    repeat (4) tick();
    chk(!op_busy && nlog == 0, "R11 opcode 3 ignored", nlog, 0);
  endtask

  task automatic t_dev_reset();
    cfg_setup = 4'd0; cfg_width = 4'd6; cfg_hold = 4'd2;
    launch(2'd0, '0);
    wait_done();
    chk(nlog == 1 && lg_cmd[0] && lg_b[0] == 8'hFF, "R5 single 0xFF", {nlog, lg_b[0]}, {32'd1, 8'hFF});
    chk(lg_pre[0] == 0 && lg_low[0] == 7 && lg_post[0] == 2, "R2 phases 0/6/2",
        {lg_pre[0][7:0], lg_low[0][7:0], lg_post[0][7:0]}, 24'h000702);
    chk(rise_cyc >= 0 && done_cyc > rise_cyc, "R5 done after ready", done_cyc, rise_cyc);
    chk(nf_ce_n && !op_busy, "R8 ce high after done", nf_ce_n, 1);
    chk(rnb_flag, "R10 flag set by ready rise", rnb_flag, 1);
    rnb_flag_clr = 1'b1; tick(); rnb_flag_clr = 1'b0; tick();
    chk(!rnb_flag, "R10 write-1 clears flag", rnb_flag, 0);
  endtask

  task automatic t_ident(input logic [7:0] dev, input logic [1:0] kind, input logic thr);
    cfg_setup = 4'd1; cfg_width = 4'd2; cfg_hold = 4'd1;
    id_b[0] = 8'hEC; id_b[1] = dev; id_b[2] = 8'h10; id_b[3] = 8'h95;
    throttle = thr;
    launch(2'd1, '0);
    wait_done();
    throttle = 1'b0;
    chk(nlog == 2 && lg_cmd[0] && lg_b[0] == 8'h90 && !lg_cmd[1] && lg_b[1] == 8'h00,
        "R6 cmd 0x90 then addr 0x00", {lg_b[0], lg_b[1]}, 16'h9000);
    chk(lg_pre[1] == 1 && lg_low[1] == 3 && lg_post[1] == 1, "R2 phases 1/2/1",
        {lg_pre[1][7:0], lg_low[1][7:0], lg_post[1][7:0]}, 24'h010301);
    chk(re_last == 3, "R2 read strobe width", re_last, 3);
    chk(rcnt == 4 && rbuf[0] == 8'hEC && rbuf[1] == dev && rbuf[2] == 8'h10 && rbuf[3] == 8'h95,
        "R6 R12 id bytes in order", {rbuf[0], rbuf[1], rbuf[2], rbuf[3]}, {8'hEC, dev, 8'h10, 8'h95});
    chk(page_kind == kind, "R7 page class", page_kind, kind);
    chk(oe_rd_bad == 0, "R9 no drive on read", oe_rd_bad, 0);
  endtask

  task automatic t_page(input logic [28:0] a, input int nbytes);
    logic [7:0] exp_b [7];
    int mism;
    cfg_setup = 4'd0; cfg_width = 4'd0; cfg_hold = 4'd0;
    exp_b[0] = 8'h00; exp_b[1] = a[7:0]; exp_b[2] = {4'h0, a[11:8]};
    exp_b[3] = a[19:12]; exp_b[4] = a[27:20]; exp_b[5] = {7'h00, a[28]}; exp_b[6] = 8'h30;
    launch(2'd2, a);
    repeat (60) tick();
    op_code = 2'd0; op_start = 1'b1; tick(); op_start = 1'b0;
    wait_done();
    repeat (30) tick();
    chk(nlog == 7, "R4 R11 seven bus writes", nlog, 7);
    for (int i = 0; i < 7; i++)
      chk(lg_b[i] == exp_b[i] && lg_cmd[i] == (i == 0 || i == 6), "R3 R4 address/command byte",
          {lg_cmd[i], lg_b[i]}, {(i == 0 || i == 6), exp_b[i]});
    chk(first_re > rise_cyc && rise_cyc >= 0, "R4 reads after ready", first_re, rise_cyc);
    mism = 0;
    for (int i = 0; i < nbytes && i < 2048; i++)
      if (rbuf[i] != (i[7:0] ^ a[19:12])) mism++;
    chk(rcnt == nbytes, "R4 byte count", rcnt, nbytes);
    chk(mism == 0, "R4 page data", mism, 0);
    chk(ndone == 1 && !op_busy, "R11 start while busy ignored", ndone, 1);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    t_reset_state();
    t_dev_reset();
    t_ident(8'hDA, 2'd2, 1'b1);
    t_page(29'h1ABCDEF1, 2048);
    t_ident(8'h76, 2'd1, 1'b0);
    t_page(29'h0000_3005, 512);
    t_ident(8'h42, 2'd0, 1'b1);
    report();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    report();
    $finish;
  end
endmodule